// File: doc/BRIEF.md
# Relocatable Register Bank over Dual-Port RAM

This block provides a processor's sixteen general-purpose word registers without any dedicated register storage. Every register lives in a word-addressed on-chip RAM. A programmable base pointer selects the window of sixteen consecutive words that forms the active bank. Software switches banks by loading a new pointer value. Because any pointer inside the RAM is legal, the number of banks is bounded only by RAM size.

Two windows may overlap. A caller can place arguments in its high registers, move the pointer up by a few words, and the callee then sees those same RAM words as its low registers. Each cycle the block takes two read indices and one write index. It turns each index into a RAM word address, returns both read words combinationally, and commits the write at the clock edge.

Top module: `rbank_cp`

## Requirements
- R1: Register index n (0..15, 16-bit words) maps to RAM word ((ptr >> 1) + n) modulo RAM_WORDS, where ptr is the byte-address base pointer.
- R2: Bit 0 of a loaded pointer value is discarded, so `cpValue` always reads back word-aligned. The pointer is 0 after reset.
- R3: When `wrEn` is high, `wrData` is stored at the word mapped from `wrIdx`, and a read of that word on any later cycle returns it.
- R4: A pointer load takes effect at the next clock edge. Reads and the write issued in the same cycle as the load still map through the old pointer. Without a load, the pointer holds its value.
- R5: When a read port and an active write map to the same RAM word in one cycle, that read port returns the new `wrData` in that same cycle (write-first).
- R6: Banks may overlap. A word written as register i under pointer P reads back as register i + (P - Q)/2 under pointer Q whenever that index lies in 0..15.
- R7: The two read ports are independent. Each returns the word for its own index, including when both indices are equal.
- R8: A window that runs past the last RAM word wraps to word 0.
- R9: When `wrEn` is low, no RAM word changes, whatever `wrIdx` and `wrData` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpWrEn | input | 1 | Load the base pointer |
| cpWrData | input | CP_W (9) | New pointer byte address; bit 0 is ignored |
| cpValue | output | CP_W (9) | Current base pointer |
| rdIdxA | input | 4 | Register index for read port A |
| rdDataA | output | 16 | Read data for port A |
| rdIdxB | input | 4 | Register index for read port B |
| rdDataB | output | 16 | Read data for port B |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 4 | Register index to write |
| wrData | input | 16 | Data to write |

## Verification
The bench goes after four corner cases. The first is a pointer load issued together with reads and a write; a design that applied the new pointer early would return words from the new window in that same cycle. The second is a read that hits the word being written in the same cycle; without the write-first bypass the port would return stale RAM data. The third is overlapping windows and the wrap at the end of RAM; an adder that is too narrow or mis-shifted would either alias the wrong words or fall off the top of the RAM instead of wrapping. The fourth is odd pointer values and writes with the enable low; the first would shift the window by a byte, and the second would corrupt a word.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  localparam int NUM_RD = 2;

  typedef struct packed {
    logic              wrEn;
    logic [NUM_RD-1:0] fwd;
  } rbStrobe_t;
endpackage

// File: rtl/rbank_ctrl.sv
module rbank_ctrl
  import rbank_pkg::*;
#(
  parameter int WORD_AW = 8,
  parameter int IDX_W   = 4,
  parameter int CP_W    = WORD_AW + 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cpWrEn,
  input  logic [CP_W-1:0]                    cpWrData,
  output logic [CP_W-1:0]                    cpValue,
  input  logic [NUM_RD-1:0][IDX_W-1:0]       rdIdx,
  input  logic                               wrEn,
  input  logic [IDX_W-1:0]                   wrIdx,
  output logic [NUM_RD-1:0][WORD_AW-1:0]     rdAddr,
  output logic [WORD_AW-1:0]                 wrAddr,
  output rbStrobe_t                          strobe
);
  localparam logic [CP_W-1:0] ALIGN_MASK = ~CP_W'(1);

  logic [CP_W-1:0]    cpReg;
  logic [WORD_AW-1:0] baseWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cpReg <= '0;
    else if (cpWrEn) cpReg <= cpWrData & ALIGN_MASK;
  end

  assign cpValue  = cpReg;
  assign baseWord = cpReg[CP_W-1:1];
  assign wrAddr   = baseWord + WORD_AW'(wrIdx);
  assign strobe.wrEn = wrEn;

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rdMap
    assign rdAddr[g]     = baseWord + WORD_AW'(rdIdx[g]);
    assign strobe.fwd[g] = wrEn && (rdAddr[g] == wrAddr);
  end

  // R2, R4: a load appears aligned at the next edge
  assert_cp_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpWrEn |=> cpValue == ($past(cpWrData) & ALIGN_MASK));
  // R4: pointer holds without a load
  assert_cp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpWrEn |=> $stable(cpValue));
endmodule

// File: rtl/rbank_dpath.sv
module rbank_dpath
  import rbank_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WORD_AW   = 8,
  parameter int RAM_WORDS = 1 << WORD_AW
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  rbStrobe_t                      strobe,
  input  logic [NUM_RD-1:0][WORD_AW-1:0] rdAddr,
  input  logic [WORD_AW-1:0]             wrAddr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdData
);
  logic [DATA_W-1:0] mem [RAM_WORDS];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= wrData;
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rdPort
    assign rdData[g] = strobe.fwd[g] ? wrData : mem[rdAddr[g]];

    // R5: a forwarded word equals what the RAM holds one cycle later
    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.fwd[g] |=> mem[$past(rdAddr[g])] == $past(rdData[g]));
  end

  // R3: an enabled write lands at its mapped word
  assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn |=> mem[$past(wrAddr)] == $past(wrData));
  // R9: with no write, the word read on port 0 is unchanged next cycle
  assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrEn |=> mem[$past(rdAddr[0])] == $past(rdData[0]));
endmodule

// File: rtl/rbank_cp.sv
module rbank_cp
  import rbank_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int WORD_AW = 8,
  parameter int IDX_W   = 4,
  parameter int CP_W    = WORD_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpWrEn,
  input  logic [CP_W-1:0]   cpWrData,
  output logic [CP_W-1:0]   cpValue,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData
);
  localparam int RAM_WORDS = 1 << WORD_AW;

  rbStrobe_t                      strobe;
  logic [NUM_RD-1:0][WORD_AW-1:0] rdAddr;
  logic [WORD_AW-1:0]             wrAddr;
  logic [NUM_RD-1:0][IDX_W-1:0]   rdIdx;
  logic [NUM_RD-1:0][DATA_W-1:0]  rdData;

  assign rdIdx   = {rdIdxB, rdIdxA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  rbank_ctrl #(.WORD_AW(WORD_AW), .IDX_W(IDX_W), .CP_W(CP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpWrEn(cpWrEn), .cpWrData(cpWrData),
    .cpValue(cpValue), .rdIdx(rdIdx), .wrEn(wrEn), .wrIdx(wrIdx),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .strobe(strobe)
  );

  rbank_dpath #(.DATA_W(DATA_W), .WORD_AW(WORD_AW), .RAM_WORDS(RAM_WORDS)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdAddr(rdAddr),
    .wrAddr(wrAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/rbank_cp_bench.sv
module rbank_cp_bench;
  localparam int DW = 16, AW = 8, IW = 4, CW = AW + 1, WORDS = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpWrEn = 1'b0, wrEn = 1'b0;
  logic [CW-1:0] cpWrData = '0, cpValue;
  logic [IW-1:0] rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic [DW-1:0] rdDataA, rdDataB, wrData = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [WORDS];
  logic [CW-1:0] cpModel = '0;

  always #2.5 clk = ~clk;

  rbank_cp u_rbank_cp (.*);

  function automatic logic [AW-1:0] mapWord(logic [CW-1:0] p, logic [IW-1:0] i);
    return AW'(p >> 1) + AW'(i);
  endfunction

  function automatic logic [DW-1:0] expRead(logic [IW-1:0] i, logic we,
                                            logic [IW-1:0] wi, logic [DW-1:0] wd);
    logic [AW-1:0] a = mapWord(cpModel, i);
    if (we && a == mapWord(cpModel, wi)) return wd;
    return model[a];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, check combinational reads, commit at edge, update model.
  task automatic step(logic cw, logic [CW-1:0] cd, logic we, logic [IW-1:0] wi,
                      logic [DW-1:0] wd, logic [IW-1:0] ia, logic [IW-1:0] ib,
                      string req);
    cpWrEn = cw; cpWrData = cd; wrEn = we; wrIdx = wi; wrData = wd;
    rdIdxA = ia; rdIdxB = ib;
    #1;
    check({req, " portA"}, 32'(rdDataA), 32'(expRead(ia, we, wi, wd)));
    check({req, " portB"}, 32'(rdDataB), 32'(expRead(ib, we, wi, wd)));
    @(posedge clk); #1;
    if (we) model[mapWord(cpModel, wi)] = wd;
    if (cw) cpModel = cd & ~CW'(1);
    check({req, " ptr"}, 32'(cpValue), 32'(cpModel));
    cpWrEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    #7; rst_n = 1'b1;
    @(posedge clk); #1;
    check("R2 reset ptr", 32'(cpValue), 32'd0);

    // Fill every word: banks at pointer steps of 32 bytes (R1, R3)
    for (int b = 0; b < WORDS / 16; b++) begin
      step(1'b1, CW'(b * 32), 1'b0, '0, '0, '0, '0, "R1 setptr");
      for (int r = 0; r < 16; r++)
        step(1'b0, '0, 1'b1, IW'(r), DW'(16'hA000 + b * 16 + r), IW'(r), '0, "R3 fill");
    end
    step(1'b1, CW'(0), 1'b0, '0, '0, 4'd3, 4'd15, "R1 readback");
    step(1'b0, '0, 1'b0, '0, '0, 4'd7, 4'd7, "R7 same index");

    // Overlap: write R12 at ptr 0x40, read as R4 at ptr 0x50 (R6)
    step(1'b1, CW'(9'h040), 1'b0, '0, '0, '0, '0, "R6 ptr");
    step(1'b0, '0, 1'b1, 4'd12, 16'hBEEF, 4'd12, 4'd0, "R6 write");
    step(1'b1, CW'(9'h050), 1'b0, '0, '0, 4'd12, 4'd4, "R4 old ptr read");
    step(1'b0, '0, 1'b0, '0, '0, 4'd4, 4'd0, "R6 overlap read");
    check("R6 aliased word", 32'(rdDataA), 32'h0000BEEF);

    // Load with same-cycle write: write uses old ptr (R4)
    step(1'b1, CW'(9'h080), 1'b1, 4'd2, 16'h1234, 4'd2, 4'd3, "R4 load+write");
    step(1'b1, CW'(9'h050), 1'b0, '0, '0, 4'd2, 4'd3, "R4 new ptr");
    check("R4 write used old ptr", 32'(rdDataA), 32'h00001234);

    // Odd pointer ignored bit (R2)
    step(1'b1, CW'(9'h021), 1'b0, '0, '0, '0, '0, "R2 odd ptr");
    step(1'b0, '0, 1'b0, '0, '0, 4'd0, 4'd1, "R2 aligned window");

    // Write-first bypass on both ports (R5)
    step(1'b0, '0, 1'b1, 4'd9, 16'h5A5A, 4'd9, 4'd9, "R5 bypass");
    step(1'b0, '0, 1'b0, '0, '0, 4'd9, 4'd8, "R5 stored");

    // Wrap past top of RAM (R8)
    step(1'b1, CW'(9'h1F8), 1'b0, '0, '0, '0, '0, "R8 ptr");
    step(1'b0, '0, 1'b1, 4'd10, 16'hC0DE, 4'd10, 4'd3, "R8 wrap write");
    step(1'b1, CW'(0), 1'b0, '0, '0, 4'd6, 4'd0, "R8 wrap");
    step(1'b0, '0, 1'b0, '0, '0, 4'd6, 4'd0, "R8 word6");
    check("R8 wrapped word", 32'(rdDataA), 32'h0000C0DE);

    // Disabled write leaves RAM alone (R9)
    step(1'b0, '0, 1'b0, 4'd5, 16'hDEAD, 4'd5, 4'd5, "R9 no write");
    step(1'b0, '0, 1'b0, '0, '0, 4'd5, 4'd6, "R9 unchanged");

    // Constrained random traffic
    for (int k = 0; k < 3000; k++) begin
      logic cw = ($urandom % 8) == 0;
      logic [CW-1:0] cd = CW'($urandom);
      logic we = ($urandom % 4) != 0;
      logic [IW-1:0] wi = IW'($urandom);
      logic [IW-1:0] ia = (($urandom % 4) == 0) ? wi : IW'($urandom);
      logic [IW-1:0] ib = IW'($urandom);
      step(cw, cd, we, wi, DW'($urandom), ia, ib, "R1 R3 R4 R5 R6 random");
    end
    finishRun();
  end
endmodule